// File: doc/BRIEF.md
# Rate-Selectable Timer with Masked Interrupt Controller

This block combines a periodic timer and a small interrupt controller for three event sources. A prescaler divides the system clock by `BASE_DIV` to form a base tick, nominally 37.5 kHz. A rate divider then passes every Nth base tick as the timer tick. N is a power of two chosen by a 3-bit code.

The controller holds an enable word and a request word. The timer tick and two DMA completion pulses (one from the card channel, one from the audio channel) each set their own request bit. The interrupt line is high while any pending request is also enabled.

Software never stores the enable or request word directly. Each write carries an action bit that selects whether the flagged bits are raised or dropped, and bits left at zero keep their value.

Top module: `tick_irq_ctrl`

## Requirements
- R1: After reset the rate code, the enable word and the request word are all zero, and `irq` is low.
- R2: With rate code 0, `timer_tick` pulses for one cycle every `BASE_DIV` clock cycles.
- R3: Rate codes 1 to 7, written to bits 2:0 when `reg_sel`=0, give a tick period of `BASE_DIV` times 2, 4, 8, 16, 64, 256 and 1024 respectively.
- R4: Any write with `reg_sel`=0 restarts both dividers. The first tick then occurs in cycle N*`BASE_DIV`-1, where cycle 0 is the cycle after the write edge.
- R5: A write with `reg_sel`=1 changes the enable word. If `reg_wdata`[7] is 1, each bit 2:0 given as 1 is set. If `reg_wdata`[7] is 0, each such bit is cleared. Bits given as 0 are unchanged.
- R6: A write with `reg_sel`=2 changes the request word using the same set/clear rule as R5.
- R7: Request bit 0 is set by `timer_tick`, bit 1 by `card_dma_done` and bit 2 by `audio_dma_done`, whatever the enable word holds.
- R8: `irq` is high exactly when some bit is 1 in both the request word and the enable word.
- R9: If a source pulse arrives in the same cycle as a write that clears its request bit, the bit stays set.
- R10: Reads return the selected word in `reg_rdata` bits 2:0, with bits 7:3 zero. `reg_sel`=3 reads zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 rate, 1 enable, 2 request, 3 none |
| reg_wdata | input | 8 | Write data; bit 7 is the set/clear action for enable and request |
| reg_rdata | output | 8 | Read data of the selected register |
| card_dma_done | input | 1 | One-cycle completion pulse from the card DMA channel |
| audio_dma_done | input | 1 | One-cycle completion pulse from the audio DMA channel |
| timer_tick | output | 1 | One-cycle timer pulse at the selected rate |
| irq | output | 1 | Interrupt request line |

## Verification
A completion pulse can arrive in the same cycle as a software write that clears the matching request bit. The bench provokes this by raising `card_dma_done` on the same edge as a request-clear write. That write also clears another bit, which shows the clear was applied. The bench then reads the request word and expects the pulsed bit to stay set while the other bit drops.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
    localparam int NSRC      = 3;
    localparam int CODE_W    = 3;
    localparam int MAX_SHIFT = 10;
    localparam int DIV_W     = MAX_SHIFT;

    typedef enum logic [1:0] {
        SEL_RATE = 2'd0,
        SEL_EN   = 2'd1,
        SEL_REQ  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // rate code to power-of-two exponent; codes 5..7 skip ahead by two
    function automatic int code_shift(input logic [CODE_W-1:0] code);
        int s;
        if (code <= 3'd4) s = int'(code);
        else              s = 2 * int'(code) - 4;
        return s;
    endfunction
endpackage

// File: rtl/tirq_prescale.sv
module tirq_prescale #(
    parameter int BASE_DIV = 2667
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic base_pulse
);
    localparam int PRE_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(BASE_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart)                st_d.cnt = '0;
        else if (st_q.cnt == LAST)  st_d.cnt = '0;
        else                        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_pulse = (st_q.cnt == LAST);

    p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));
endmodule

// File: rtl/tirq_ratediv.sv
module tirq_ratediv
    import tirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] code_in,
    input  logic              base_pulse,
    output logic [CODE_W-1:0] code_out,
    output logic              tick
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [DIV_W-1:0]  cnt;
    } div_t;

    div_t st_d, st_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = DIV_W'((1 << code_shift(st_q.code)) - 1);
        tick = base_pulse && (st_q.cnt == lim);
        st_d = st_q;
        if (code_wr) begin
            st_d.code = code_in;
            st_d.cnt  = '0;
        end else if (base_pulse) begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_out = st_q.code;

    p_tick_on_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> base_pulse);
    p_code_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !code_wr |=> $stable(st_q.code));
endmodule

// File: rtl/tirq_regs.sv
module tirq_regs
    import tirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic            req_wr,
    input  logic [7:0]      wdata,
    input  logic [NSRC-1:0] src,
    output logic [NSRC-1:0] en_out,
    output logic [NSRC-1:0] req_out
);
    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] req;
    } irq_t;

    irq_t st_d, st_q;
    logic [NSRC-1:0] flag;

    function automatic logic [NSRC-1:0] apply(input logic [NSRC-1:0] cur,
                                              input logic [NSRC-1:0] f,
                                              input logic set);
        return set ? (cur | f) : (cur & ~f);
    endfunction

    always_comb begin
        flag = wdata[NSRC-1:0];
        st_d = st_q;
        if (en_wr)  st_d.en  = apply(st_q.en,  flag, wdata[7]);
        if (req_wr) st_d.req = apply(st_q.req, flag, wdata[7]);
        st_d.req = st_d.req | src;   // a live pulse beats a clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_out  = st_q.en;
    assign req_out = st_q.req;

    p_src_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        src[1] |=> req_out[1]);
    p_pulse_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !wdata[7] && wdata[2] && src[2]) |=> req_out[2]);
    p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en_out));
    p_req_noset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_wr && src == '0) |=> (req_out & ~$past(req_out)) == '0);
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
    import tirq_pkg::*;
#(
    parameter int BASE_DIV = 2667
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       card_dma_done,
    input  logic       audio_dma_done,
    output logic       timer_tick,
    output logic       irq
);
    logic              base_pulse;
    logic              rate_wr;
    logic [CODE_W-1:0] code;
    logic [NSRC-1:0]   en_w, req_w, src;

    assign rate_wr = reg_wr && (reg_sel == SEL_RATE);
    assign src     = {audio_dma_done, card_dma_done, timer_tick};

    tirq_prescale #(.BASE_DIV(BASE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(rate_wr), .base_pulse(base_pulse)
    );

    tirq_ratediv u_div (
        .clk(clk), .rst_n(rst_n), .code_wr(rate_wr),
        .code_in(reg_wdata[CODE_W-1:0]), .base_pulse(base_pulse),
        .code_out(code), .tick(timer_tick)
    );

    tirq_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .en_wr(reg_wr && (reg_sel == SEL_EN)),
        .req_wr(reg_wr && (reg_sel == SEL_REQ)),
        .wdata(reg_wdata), .src(src),
        .en_out(en_w), .req_out(req_w)
    );

    always_comb begin
        case (reg_sel)
            SEL_RATE: reg_rdata = {{(8-CODE_W){1'b0}}, code};
            SEL_EN:   reg_rdata = {{(8-NSRC){1'b0}}, en_w};
            SEL_REQ:  reg_rdata = {{(8-NSRC){1'b0}}, req_w};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(req_w & en_w);

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w == '0) |-> !irq);
    p_rdata_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:3] == 5'd0);
endmodule

// File: tb/tick_irq_ctrl_test.sv
module tick_irq_ctrl_test;
    localparam int B = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic card_dma_done = 1'b0;
    logic audio_dma_done = 1'b0;
    logic timer_tick, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_irq_ctrl #(.BASE_DIV(B)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .card_dma_done(card_dma_done), .audio_dma_done(audio_dma_done),
        .timer_tick(timer_tick), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic test_reset();
        logic [7:0] v;
        rd(2'd0, v); chk(v == 8'd0, "R1 rate", v, 0);
        rd(2'd1, v); chk(v == 8'd0, "R1 enable", v, 0);
        rd(2'd2, v); chk(v == 8'd0, "R1 request", v, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    task automatic test_period(input int code, input int n);
        int c, c2;
        wr(2'd0, 8'(code));
        c = 0;
        while (!timer_tick && c < 10000) begin @(negedge clk); c++; end
        chk(c == n*B-1, (code == 0) ? "R4/R2 first tick" : "R4/R3 first tick", c, n*B-1);
        @(negedge clk);
        c2 = 1;
        while (!timer_tick && c2 < 10000) begin @(negedge clk); c2++; end
        chk(c2 == n*B, (code == 0) ? "R2 period" : "R3 period", c2, n*B);
    endtask

    task automatic test_restart();
        int c;
        logic [7:0] v;
        wr(2'd0, 8'd2);
        repeat (6) @(negedge clk);
        wr(2'd0, 8'd2);
        c = 0;
        while (!timer_tick && c < 1000) begin @(negedge clk); c++; end
        chk(c == 4*B-1, "R4 restart mid-count", c, 4*B-1);
        @(negedge clk);
        rd(2'd2, v); chk(v[0] == 1'b1, "R7 timer sets bit0", v[0], 1);
    endtask

    task automatic test_enable();
        logic [7:0] v;
        wr(2'd1, 8'hFF); rd(2'd1, v); chk(v == 8'h07, "R5 set all", v, 7);
        wr(2'd1, 8'h06); rd(2'd1, v); chk(v == 8'h01, "R5 clear 1,2", v, 1);
        wr(2'd1, 8'h84); rd(2'd1, v); chk(v == 8'h05, "R5 set 2 keeps 0", v, 5);
        wr(2'd1, 8'h7F); rd(2'd1, v); chk(v == 8'h00, "R5 clear all", v, 0);
    endtask

    task automatic test_request();
        logic [7:0] v;
        wr(2'd0, 8'd7);
        wr(2'd2, 8'h07);
        rd(2'd2, v); chk(v == 8'h00, "R6 clear all", v, 0);
        wr(2'd2, 8'h85); rd(2'd2, v); chk(v == 8'h05, "R6 set 0,2", v, 5);
        wr(2'd2, 8'h01); rd(2'd2, v); chk(v == 8'h04, "R6 clear 0", v, 4);
        wr(2'd2, 8'h04);
    endtask

    task automatic test_sources();
        logic [7:0] v;
        @(negedge clk); audio_dma_done = 1'b1;
        @(negedge clk); audio_dma_done = 1'b0;
        rd(2'd2, v); chk(v == 8'h04, "R7 audio sets bit2 while disabled", v, 4);
        chk(irq == 1'b0, "R8 irq low when disabled", irq, 0);
        @(negedge clk); card_dma_done = 1'b1;
        @(negedge clk); card_dma_done = 1'b0;
        rd(2'd2, v); chk(v == 8'h06, "R7 card sets bit1", v, 6);
    endtask

    task automatic test_irq();
        wr(2'd1, 8'h82); #1 chk(irq == 1'b1, "R8 enabled pending", irq, 1);
        wr(2'd1, 8'h02); #1 chk(irq == 1'b0, "R8 enable dropped", irq, 0);
        wr(2'd1, 8'h81); #1 chk(irq == 1'b0, "R8 enable without request", irq, 0);
        wr(2'd1, 8'h82); #1 chk(irq == 1'b1, "R8 re-enabled", irq, 1);
        wr(2'd2, 8'h06); #1 chk(irq == 1'b0, "R8 request cleared", irq, 0);
    endtask

    task automatic test_collision();
        logic [7:0] v;
        wr(2'd2, 8'h86);
        @(negedge clk);
        reg_sel = 2'd2; reg_wdata = 8'h06; reg_wr = 1'b1; card_dma_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; card_dma_done = 1'b0;
        rd(2'd2, v); chk(v == 8'h02, "R9 pulse beats clear", v, 2);
    endtask

    task automatic test_reads();
        logic [7:0] v;
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk(v == 8'h00, "R10 unused select", v, 0);
        rd(2'd1, v); chk(v == 8'h03, "R10 unused write ignored", v, 3);
        wr(2'd0, 8'hFD);
        rd(2'd0, v); chk(v == 8'h05, "R10 rate readback", v, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_period(0, 1);
        test_period(1, 2);
        test_period(2, 4);
        test_period(3, 8);
        test_period(4, 16);
        test_period(5, 64);
        test_period(6, 256);
        test_period(7, 1024);
        test_restart();
        test_enable();
        test_request();
        test_sources();
        test_irq();
        test_collision();
        test_reads();
        done = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 200000) begin @(posedge clk); n++; end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=done", n);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule